// File: doc/BRIEF.md
# Eight-bit timer with one compare channel

The block is an 8-bit up-counter that advances once per enabled timer tick, a compare register matched against it every cycle, and one waveform pin driven from the match result. A CPU reaches the control, counter, compare and flag registers over a small register bus. Reads return data in the same cycle. Writes take effect at the next clock edge. The tick comes in as a single-cycle enable from a prescaler outside the block. A 3-bit clock-select field either gates that tick off, with a value of zero, or lets it through, with any other value.

Two counting sequences are available. In free-running mode the counter wraps from its maximum back to zero and raises the overflow flag. In clear-on-match mode the counter returns to zero on the tick that finds it equal to the compare value. Each of the two flags produces an interrupt request when its enable bit and the global interrupt enable input are both high. A flag is cleared either by an acknowledge input when its interrupt is serviced or by a software write-one-to-clear.

Top module: `tmr8_oc`

## Requirements
- R1: After reset the counter, compare, control, flag and enable registers read zero, and the waveform pin is low.
- R2: While the clock-select field (control bits [6:4]) is zero, ticks leave the counter and the flags unchanged.
- R3: When clock-select is non-zero and the waveform mode (control bits [1:0]) is not 01, each tick adds one to the counter. A tick at 0xFF wraps the counter to 0x00 and sets the overflow flag (flag register bit 1).
- R4: In waveform mode 01, a tick that finds the counter equal to the compare register loads the counter with zero.
- R5: The compare flag (flag register bit 0) sets on the tick that finds counter and compare equal, which is the tick after the counter reached the compare value, and not when equality first appears.
- R6: A bus write to the counter (address 1) in the same cycle as a tick stores the written value. That tick then has no effect on the flags or the pin.
- R7: Writing a one to flag register bit 0 or bit 1 (address 3), or pulsing the matching acknowledge input, clears that flag. A hardware set in the same cycle takes priority over the clear.
- R8: The compare request is high exactly when the compare flag, the compare enable (address 3 bit 4) and the global enable input are all high. The overflow request works the same way with flag bit 1 and enable bit 5.
- R9: The pin action on a compare match is selected by compare-output mode (control bits [3:2]): 01 toggles the pin, 10 drives it low and 11 drives it high. Mode 00 holds the pin low.
- R10: The max indication is high exactly when the counter is 0xFF, and the bottom indication is high exactly when it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled timer tick enable |
| gie_i | input | 1 | Global interrupt enable |
| cmp_ack_i | input | 1 | Compare interrupt serviced, clears compare flag |
| ovf_ack_i | input | 1 | Overflow interrupt serviced, clears overflow flag |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 counter, 2 compare, 3 flags and enables |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| cmp_irq_o | output | 1 | Compare interrupt request |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| wave_o | output | 1 | Compare waveform pin |
| cnt_max_o | output | 1 | Counter at maximum |
| cnt_bot_o | output | 1 | Counter at zero |

## Verification
The hardest situations to reach are the same-cycle collisions: a counter write that lands on a matching tick, and a flag clear that lands on a flag set. Both require a tick and a bus write presented together in one cycle. The bench first loads the counter so that it already equals the compare value. It then drives the tick and the write in the same cycle, and reads back the counter and the flags one cycle later. The pin modes are stepped through one match at a time, with the counter reloaded before each tick.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    typedef enum logic [1:0] {
        WM_FREE     = 2'b00,
        WM_CLRMATCH = 2'b01,
        WM_RSV2     = 2'b10,
        WM_RSV3     = 2'b11
    } wmode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_LOW    = 2'b10,
        OM_HIGH   = 2'b11
    } omode_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CNT  = 2'd1;
    localparam logic [1:0] A_CMP  = 2'd2;
    localparam logic [1:0] A_FLAG = 2'd3;
endpackage

// File: rtl/tmr8_count.sv
module tmr8_count #(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic         step_i,
    input  logic         up_i,
    input  logic         clr_i,
    output logic [W-1:0] nxt_o,
    output logic         max_o,
    output logic         bot_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        nxt_o = cnt_i;
        if (step_i) begin
            if (clr_i)     nxt_o = '0;
            else if (up_i) nxt_o = cnt_i + ONE;
            else           nxt_o = cnt_i - ONE;
        end
    end

    assign max_o = (cnt_i == '1);
    assign bot_o = (cnt_i == '0);
endmodule

// File: rtl/tmr8_ocmp.sv
module tmr8_ocmp
    import tmr8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cmp_i,
    input  logic [1:0]   mode_i,
    input  logic         fire_i,
    input  logic         oc_i,
    output logic         match_o,
    output logic         oc_o,
    output logic         pin_o
);
    always_comb begin
        match_o = (cnt_i == cmp_i);
        oc_o    = oc_i;
        if (fire_i && match_o) begin
            unique case (omode_e'(mode_i))
                OM_TOGGLE: oc_o = ~oc_i;
                OM_LOW:    oc_o = 1'b0;
                OM_HIGH:   oc_o = 1'b1;
                default:   oc_o = oc_i;
            endcase
        end
        pin_o = (omode_e'(mode_i) == OM_OFF) ? 1'b0 : oc_i;
    end
endmodule

// File: rtl/tmr8_oc.sv
module tmr8_oc
    import tmr8_pkg::*;
#(
    parameter int W   = 8,
    parameter int CSW = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         gie_i,
    input  logic         cmp_ack_i,
    input  logic         ovf_ack_i,
    input  logic         bus_we_i,
    input  logic [1:0]   bus_addr_i,
    input  logic [W-1:0] bus_wdata_i,
    output logic [W-1:0] bus_rdata_o,
    output logic         cmp_irq_o,
    output logic         ovf_irq_o,
    output logic         wave_o,
    output logic         cnt_max_o,
    output logic         cnt_bot_o
);
    localparam int CS_LSB = 4;

    typedef struct packed {
        logic [1:0]     wmode;
        logic [1:0]     omode;
        logic [CSW-1:0] csel;
        logic [W-1:0]   cnt;
        logic [W-1:0]   cmp;
        logic           cflag;
        logic           oflag;
        logic           cie;
        logic           oie;
        logic           oc;
    } st_t;

    st_t st_d, st_q;

    logic ctrl_wr, cnt_wr, cmp_wr, flg_wr, tick_ok, match, oc_nxt;
    logic [W-1:0] cnt_nxt;

    assign ctrl_wr = bus_we_i && (bus_addr_i == A_CTRL);
    assign cnt_wr  = bus_we_i && (bus_addr_i == A_CNT);
    assign cmp_wr  = bus_we_i && (bus_addr_i == A_CMP);
    assign flg_wr  = bus_we_i && (bus_addr_i == A_FLAG);
    assign tick_ok = tick_i && (st_q.csel != '0) && !cnt_wr;

    tmr8_ocmp #(.W(W)) ocmp_i (
        .cnt_i   (st_q.cnt),
        .cmp_i   (st_q.cmp),
        .mode_i  (st_q.omode),
        .fire_i  (tick_ok),
        .oc_i    (st_q.oc),
        .match_o (match),
        .oc_o    (oc_nxt),
        .pin_o   (wave_o)
    );

    tmr8_count #(.W(W)) count_i (
        .cnt_i  (st_q.cnt),
        .step_i (tick_ok),
        .up_i   (1'b1),
        .clr_i  ((wmode_e'(st_q.wmode) == WM_CLRMATCH) && match),
        .nxt_o  (cnt_nxt),
        .max_o  (cnt_max_o),
        .bot_o  (cnt_bot_o)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.wmode = bus_wdata_i[1:0];
            st_d.omode = bus_wdata_i[3:2];
            st_d.csel  = bus_wdata_i[CS_LSB +: CSW];
        end
        st_d.cnt = cnt_wr ? bus_wdata_i : cnt_nxt;
        if (cmp_wr) st_d.cmp = bus_wdata_i;
        st_d.cflag = (st_q.cflag && !(cmp_ack_i || (flg_wr && bus_wdata_i[0])))
                     || (tick_ok && match);
        st_d.oflag = (st_q.oflag && !(ovf_ack_i || (flg_wr && bus_wdata_i[1])))
                     || (tick_ok && cnt_max_o);
        if (flg_wr) begin
            st_d.cie = bus_wdata_i[4];
            st_d.oie = bus_wdata_i[5];
        end
        st_d.oc = oc_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (bus_addr_i)
            A_CTRL: begin
                bus_rdata_o[1:0]             = st_q.wmode;
                bus_rdata_o[3:2]             = st_q.omode;
                bus_rdata_o[CS_LSB +: CSW]   = st_q.csel;
            end
            A_CNT:  bus_rdata_o = st_q.cnt;
            A_CMP:  bus_rdata_o = st_q.cmp;
            default: begin
                bus_rdata_o[0] = st_q.cflag;
                bus_rdata_o[1] = st_q.oflag;
                bus_rdata_o[4] = st_q.cie;
                bus_rdata_o[5] = st_q.oie;
            end
        endcase
    end

    assign cmp_irq_o = st_q.cflag && st_q.cie && gie_i;
    assign ovf_irq_o = st_q.oflag && st_q.oie && gie_i;

    logic [W-1:0]   cnt_w, cmp_w;
    logic [CSW-1:0] csel_w;
    logic [1:0]     wmode_w, omode_w;
    logic           cflag_w;
    assign cnt_w   = st_q.cnt;
    assign cmp_w   = st_q.cmp;
    assign csel_w  = st_q.csel;
    assign wmode_w = st_q.wmode;
    assign omode_w = st_q.omode;
    assign cflag_w = st_q.cflag;
endmodule

// File: rtl/tmr8_oc_chk.sv
module tmr8_oc_chk #(
    parameter int W   = 8,
    parameter int CSW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic           gie_i,
    input logic           bus_we_i,
    input logic [1:0]     bus_addr_i,
    input logic [W-1:0]   bus_wdata_i,
    input logic [W-1:0]   cnt,
    input logic [W-1:0]   cmp,
    input logic [CSW-1:0] csel,
    input logic [1:0]     wmode,
    input logic [1:0]     omode,
    input logic           cflag,
    input logic           cmp_irq_o,
    input logic           wave_o,
    input logic           cnt_max_o
);
    logic cwr, live;
    assign cwr  = bus_we_i && (bus_addr_i == 2'd1);
    assign live = tick_i && (csel != '0) && !cwr;

    a_r2_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (csel == '0 && !cwr) |=> $stable(cnt));

    a_r4_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (live && wmode == 2'b01 && cnt == cmp) |=> (cnt == '0));

    a_r5_flag_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (live && cnt == cmp) |=> cflag);

    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cwr |=> (cnt == $past(bus_wdata_i)));

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_irq_o |-> (gie_i && cflag));

    a_r9_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (omode == 2'b00) |-> !wave_o);

    a_r10_max_ind: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_max_o |-> (cnt == '1));
endmodule

bind tmr8_oc tmr8_oc_chk #(.W(W), .CSW(CSW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .gie_i       (gie_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt         (cnt_w),
    .cmp         (cmp_w),
    .csel        (csel_w),
    .wmode       (wmode_w),
    .omode       (omode_w),
    .cflag       (cflag_w),
    .cmp_irq_o   (cmp_irq_o),
    .wave_o      (wave_o),
    .cnt_max_o   (cnt_max_o)
);

// File: tb/tmr8_oc_tb_top.sv
module tmr8_oc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0, gie_i = 1'b0, cmp_ack_i = 1'b0, ovf_ack_i = 1'b0;
    logic       bus_we_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic [7:0] bus_wdata_i = 8'h00;
    logic [7:0] bus_rdata_o;
    logic       cmp_irq_o, ovf_irq_o, wave_o, cnt_max_o, cnt_bot_o;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    tmr8_oc dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gie_i(gie_i),
        .cmp_ack_i(cmp_ack_i), .ovf_ack_i(ovf_ack_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .cmp_irq_o(cmp_irq_o), .ovf_irq_o(ovf_irq_o), .wave_o(wave_o),
        .cnt_max_o(cnt_max_o), .cnt_bot_o(cnt_bot_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        bus_addr_i = a;
        #1;
        chk(bus_rdata_o == exp, req, bus_rdata_o, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_i = 1'b1;
        repeat (n) @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk(2'd0, 8'h00, "R1 ctrl");
        rd_chk(2'd1, 8'h00, "R1 cnt");
        rd_chk(2'd2, 8'h00, "R1 cmp");
        rd_chk(2'd3, 8'h00, "R1 flags");
        chk(wave_o == 1'b0, "R1 pin", wave_o, 0);
        chk(cnt_bot_o && !cnt_max_o, "R10 bottom at reset", {cnt_bot_o, cnt_max_o}, 2);
    endtask

    task automatic t_stopped();
        ticks(5);
        rd_chk(2'd1, 8'h00, "R2 stopped count");
        rd_chk(2'd3, 8'h00, "R2 stopped flags");
    endtask

    task automatic t_wrap();
        wr(2'd0, 8'h10);
        wr(2'd1, 8'hFD);
        ticks(2);
        rd_chk(2'd1, 8'hFF, "R3 increment");
        chk(cnt_max_o == 1'b1, "R10 max", cnt_max_o, 1);
        rd_chk(2'd3, 8'h00, "R3 no overflow yet");
        ticks(1);
        rd_chk(2'd1, 8'h00, "R3 wrap");
        rd_chk(2'd3, 8'h02, "R3 overflow flag");
        wr(2'd3, 8'h03);
        rd_chk(2'd3, 8'h00, "R7 w1c overflow");
    endtask

    task automatic t_ctc_flag();
        wr(2'd2, 8'h05);
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h03);
        ticks(1);
        rd_chk(2'd1, 8'h04, "R4 count toward match");
        ticks(1);
        rd_chk(2'd1, 8'h05, "R5 counter reached compare");
        rd_chk(2'd3, 8'h00, "R5 flag not yet set");
        ticks(1);
        rd_chk(2'd1, 8'h00, "R4 clear on match");
        rd_chk(2'd3, 8'h01, "R5 flag one tick later");
        chk(cnt_bot_o == 1'b1, "R10 bottom", cnt_bot_o, 1);
        wr(2'd3, 8'h10);
        #1 chk(cmp_irq_o == 1'b0, "R8 gie low", cmp_irq_o, 0);
        gie_i = 1'b1;
        #1 chk(cmp_irq_o == 1'b1, "R8 all enabled", cmp_irq_o, 1);
        chk(ovf_irq_o == 1'b0, "R8 overflow quiet", ovf_irq_o, 0);
        @(negedge clk); cmp_ack_i = 1'b1;
        @(negedge clk); cmp_ack_i = 1'b0;
        rd_chk(2'd3, 8'h10, "R7 ack clears");
        chk(cmp_irq_o == 1'b0, "R8 irq drops", cmp_irq_o, 1'b0);
    endtask

    task automatic t_set_priority();
        wr(2'd1, 8'h05);
        @(negedge clk);
        tick_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 2'd3; bus_wdata_i = 8'h11;
        @(negedge clk);
        tick_i = 1'b0; bus_we_i = 1'b0;
        rd_chk(2'd3, 8'h11, "R7 set beats clear");
        rd_chk(2'd1, 8'h00, "R4 cleared during priority");
    endtask

    task automatic t_write_wins();
        wr(2'd3, 8'h11);
        rd_chk(2'd3, 8'h10, "R7 w1c compare");
        wr(2'd1, 8'h05);
        @(negedge clk);
        tick_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 2'd1; bus_wdata_i = 8'h40;
        @(negedge clk);
        tick_i = 1'b0; bus_we_i = 1'b0;
        rd_chk(2'd1, 8'h40, "R6 write wins");
        rd_chk(2'd3, 8'h10, "R6 no flag on write cycle");
    endtask

    task automatic pin_step(input logic [7:0] ctrl, input logic exp, input string req);
        wr(2'd0, ctrl);
        wr(2'd1, 8'h02);
        ticks(1);
        #1 chk(wave_o == exp, req, wave_o, exp);
    endtask

    task automatic t_pin();
        wr(2'd2, 8'h02);
        pin_step(8'h15, 1'b1, "R9 toggle high");
        pin_step(8'h15, 1'b0, "R9 toggle low");
        pin_step(8'h1D, 1'b1, "R9 set");
        pin_step(8'h19, 1'b0, "R9 clear");
        pin_step(8'h1D, 1'b1, "R9 set again");
        wr(2'd0, 8'h11);
        #1 chk(wave_o == 1'b0, "R9 disconnected low", wave_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stopped();
        t_wrap();
        t_ctc_flag();
        t_set_priority();
        t_write_wins();
        t_pin();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule